// File: doc/BRIEF.md
# Single-Precision NaN Quieting Unit

This block takes one 32-bit single-precision operand and sorts it into one of six classes: zero, denormal, normal, infinity, quiet NaN or signaling NaN. It then produces a result word, and only NaN inputs are ever changed. This encoding treats a NaN as signaling when the top fraction bit is set. A quiet NaN goes through untouched. A signaling NaN always raises the invalid-operation cause flag. When the invalid-operation trap is not enabled, the signaling NaN is quieted by clearing its top fraction bit. If clearing that bit would leave an infinity, the block returns the default NaN instead. When the trap is enabled, the signaling NaN is returned as it came in.

Operands arrive on a valid/ready stream. The trap-enable pin is a plain control input that is sampled with each accepted operand. The processed result, the class and the flags leave on a registered valid/ready stream, one cycle after acceptance. Back-pressure works as follows. While the output holds a word that the consumer has not taken (out_valid high, out_ready low), the output word and flags stay frozen and in_ready is low. in_ready is high whenever the output register is empty or is being drained in the same cycle.

Top module: `sp_nan_quiet_unit`

## Requirements
- R1: The class code reports the operand by its exponent and fraction fields, regardless of sign. Code 0 is zero (exponent 0, fraction 0). Code 1 is denormal (exponent 0, fraction nonzero). Code 2 is normal (exponent neither 0 nor all ones). Code 3 is infinity (exponent all ones, fraction 0).
- R2: An operand with an all-ones exponent and a nonzero fraction is a NaN. Its code is 5 (signaling) when fraction bit 22 is 1 and 4 (quiet) when bit 22 is 0. The is-NaN flag is 1 exactly for codes 4 and 5, and the signaling flag is 1 exactly for code 5.
- R3: A quiet NaN produces a result equal to the operand and a clear invalid flag, whatever the trap-enable value.
- R4: A signaling NaN sets the invalid-operation cause flag, whether or not the trap is enabled.
- R5: A signaling NaN with the trap disabled produces the operand with bit 22 cleared. The sign, exponent and all other fraction bits are kept, as long as some fraction bit other than bit 22 is set.
- R6: A signaling NaN with the trap disabled whose only set fraction bit is bit 22 produces the default NaN 0x7FBFFFFF. This holds for either input sign.
- R7: A signaling NaN with the trap enabled produces a result equal to the operand.
- R8: A non-NaN operand (codes 0 to 3) produces a result equal to the operand, with the is-NaN, signaling and invalid flags all clear.
- R9: After reset, out_valid is 0 and the result, class and flag outputs are 0. An operand is accepted on a clock edge where in_valid and in_ready are both 1. It appears with out_valid = 1 after that edge.
- R10: in_ready equals (not out_valid) or out_ready. While out_valid is 1 and out_ready is 0, every output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | 32 | Single-precision operand |
| trap_en | input | 1 | Invalid-operation trap enabled; sampled with the operand |
| out_valid | output | 1 | Result word held |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Processed result |
| out_class | output | 3 | Class code of the operand (0 to 5) |
| out_is_nan | output | 1 | Operand is a NaN |
| out_is_snan | output | 1 | Operand is a signaling NaN |
| out_invalid | output | 1 | Invalid-operation cause |

## Verification
The assertions assume that the producer follows the stream rules. They also assume that in_data and trap_en carry meaningful values on every cycle where in_valid is high, since the input-to-output relations are sampled on the accepting edge. The bench drives all inputs on the falling edge and raises in_valid only with a fully defined operand and trap bit. It holds the offer until in_ready permits acceptance, and it lowers in_valid right after the accepting edge. Operands cover both signs in every class, plus the fraction patterns that sit next to the quieting boundary.

// File: rtl/sp_nanq_pkg.sv
package sp_nanq_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_DENORM = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } sp_class_e;

  typedef struct packed {
    sp_class_e cls;
    logic      is_nan;
    logic      is_snan;
    logic      invalid;
  } sp_flags_t;

  localparam int FLAGS_W = $bits(sp_flags_t);

endpackage

// File: rtl/sp_field_decode.sv
module sp_field_decode
  import sp_nanq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [MAG_W-1:0] mag,
  output sp_class_e        cls,
  output logic             is_nan,
  output logic             is_snan,
  output logic             rest_zero
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max, exp_min, frac_zero, top_bit;

  assign exp_f     = mag[MAG_W-1:FRAC_W];
  assign frac_f    = mag[FRAC_W-1:0];
  assign exp_max   = &exp_f;
  assign exp_min   = ~|exp_f;
  assign frac_zero = ~|frac_f;
  assign top_bit   = frac_f[FRAC_W-1];

  generate
    if (FRAC_W > 1) begin : g_rest
      assign rest_zero = ~|frac_f[FRAC_W-2:0];
    end else begin : g_norest
      assign rest_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    if (exp_min)            cls = frac_zero ? CLS_ZERO : CLS_DENORM;
    else if (!exp_max)      cls = CLS_NORMAL;
    else if (frac_zero)     cls = CLS_INF;
    else if (top_bit)       cls = CLS_SNAN;
    else                    cls = CLS_QNAN;
  end

  assign is_nan  = (cls >= CLS_QNAN);
  assign is_snan = (cls == CLS_SNAN);

endmodule

// File: rtl/sp_nan_quiet.sv
module sp_nan_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  input  logic         trap_en,
  input  logic         is_snan,
  input  logic         rest_zero,
  output logic [W-1:0] result,
  output logic         invalid
);

  localparam logic [W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
  localparam logic [W-1:0] TOP_MASK = ~(W'(1) << (FRAC_W-1));

  logic [W-1:0] cleared;

  assign cleared = val & TOP_MASK;
  assign invalid = is_snan;

  always_comb begin
    result = val;
    if (is_snan && !trap_en) begin
      result = rest_zero ? DEFAULT_NAN : cleared;
    end
  end

endmodule

// File: rtl/sp_out_stage.sv
module sp_out_stage #(
  parameter int PW = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_payload,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_payload
);

  logic          vld_q;
  logic [PW-1:0] pay_q;
  logic          take;

  assign in_ready    = !vld_q || out_ready;
  assign take        = in_valid && in_ready;
  assign out_valid   = vld_q;
  assign out_payload = pay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        pay_q <= in_payload;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sp_nan_quiet_unit.sv
module sp_nan_quiet_unit
  import sp_nanq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         trap_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic [2:0]   out_class,
  output logic         out_is_nan,
  output logic         out_is_snan,
  output logic         out_invalid
);

  localparam int PW = FLAGS_W + W;

  sp_class_e    cls;
  logic         is_nan, is_snan, rest_zero, invalid;
  logic [W-1:0] result;
  sp_flags_t    flags_d, flags_q;
  logic [PW-1:0] pay_d, pay_q;

  sp_field_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
    .mag       (in_data[W-2:0]),
    .cls       (cls),
    .is_nan    (is_nan),
    .is_snan   (is_snan),
    .rest_zero (rest_zero)
  );

  sp_nan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .val       (in_data),
    .trap_en   (trap_en),
    .is_snan   (is_snan),
    .rest_zero (rest_zero),
    .result    (result),
    .invalid   (invalid)
  );

  always_comb begin
    flags_d.cls     = cls;
    flags_d.is_nan  = is_nan;
    flags_d.is_snan = is_snan;
    flags_d.invalid = invalid;
  end

  assign pay_d = {flags_d, result};

  sp_out_stage #(.PW(PW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (pay_d),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (pay_q)
  );

  assign flags_q     = sp_flags_t'(pay_q[PW-1:W]);
  assign out_data    = pay_q[W-1:0];
  assign out_class   = flags_q.cls;
  assign out_is_nan  = flags_q.is_nan;
  assign out_is_snan = flags_q.is_snan;
  assign out_invalid = flags_q.invalid;

endmodule

// File: rtl/sp_nan_quiet_unit_chk.sv
module sp_nan_quiet_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         trap_en,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic [2:0]   out_class,
  input logic         out_is_nan,
  input logic         out_is_snan,
  input logic         out_invalid
);

  logic in_qnan;
  assign in_qnan = (&in_data[W-2:FRAC_W]) && (|in_data[FRAC_W-2:0])
                   && !in_data[FRAC_W-1];

  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_class) && $stable(out_invalid));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r2_snan_is_nan: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_snan |-> out_is_nan && out_class == 3'd5);

  a_r4_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_invalid == out_is_snan);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class < 3'd4 |-> !out_is_nan && !out_invalid);

  a_r5_still_nan: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_nan |-> (&out_data[W-2:FRAC_W]) && (|out_data[FRAC_W-1:0]));

  a_r3_qnan_same: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_qnan |=> out_data == $past(in_data));

endmodule

bind sp_nan_quiet_unit sp_nan_quiet_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/sp_nan_quiet_unit_tb_top.sv
`timescale 1ns/1ps
module sp_nan_quiet_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        trap_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [2:0]  out_class;
  logic        out_is_nan, out_is_snan, out_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sp_nan_quiet_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .trap_en(trap_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_class(out_class),
    .out_is_nan(out_is_nan), .out_is_snan(out_is_snan), .out_invalid(out_invalid)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [31:0] d, logic t, logic [2:0] ecls,
                        logic [31:0] eres, logic enan, logic esnan, logic einv);
    @(negedge clk);
    in_data = d; trap_en = t; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " data"}, 64'(out_data), 64'(eres));
    check({tag, " class"}, 64'(out_class), 64'(ecls));
    check({tag, " flags"}, 64'({out_is_nan, out_is_snan, out_invalid}),
          64'({enan, esnan, einv}));
  endtask

  task automatic t_reset;
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset data", 64'({out_data, out_class, out_is_nan, out_is_snan, out_invalid}), 64'd0);
    check("R10 reset ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_classes;
    run_op("R1 R8 +zero",   32'h0000_0000, 0, 3'd0, 32'h0000_0000, 0, 0, 0);
    run_op("R1 R8 -zero",   32'h8000_0000, 0, 3'd0, 32'h8000_0000, 0, 0, 0);
    run_op("R1 R8 denorm",  32'h0000_0001, 0, 3'd1, 32'h0000_0001, 0, 0, 0);
    run_op("R1 R8 -denorm", 32'h807F_FFFF, 1, 3'd1, 32'h807F_FFFF, 0, 0, 0);
    run_op("R1 R8 normal",  32'h3F80_0000, 0, 3'd2, 32'h3F80_0000, 0, 0, 0);
    run_op("R1 R8 -normal", 32'hC120_0000, 1, 3'd2, 32'hC120_0000, 0, 0, 0);
    run_op("R1 R8 +inf",    32'h7F80_0000, 0, 3'd3, 32'h7F80_0000, 0, 0, 0);
    run_op("R1 R8 -inf",    32'hFF80_0000, 1, 3'd3, 32'hFF80_0000, 0, 0, 0);
  endtask

  task automatic t_quiet_nan;
    run_op("R2 R3 qnan low",  32'h7F80_0001, 0, 3'd4, 32'h7F80_0001, 1, 0, 0);
    run_op("R2 R3 qnan trap", 32'hFFBF_FFFF, 1, 3'd4, 32'hFFBF_FFFF, 1, 0, 0);
  endtask

  task automatic t_signal_nan;
    run_op("R2 R4 R5 snan",     32'h7FC0_0001, 0, 3'd5, 32'h7F80_0001, 1, 1, 1);
    run_op("R5 snan all ones",  32'hFFFF_FFFF, 0, 3'd5, 32'hFFBF_FFFF, 1, 1, 1);
    run_op("R6 snan +bare",     32'h7FC0_0000, 0, 3'd5, 32'h7FBF_FFFF, 1, 1, 1);
    run_op("R6 snan -bare",     32'hFFC0_0000, 0, 3'd5, 32'h7FBF_FFFF, 1, 1, 1);
    run_op("R4 R7 snan trap",   32'h7FC0_0000, 1, 3'd5, 32'h7FC0_0000, 1, 1, 1);
    run_op("R7 snan trap neg",  32'hFFE0_1234, 1, 3'd5, 32'hFFE0_1234, 1, 1, 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 idle valid", 64'(out_valid), 64'd0);
    out_ready = 1'b0;
    run_op("R10 first", 32'h4000_0000, 0, 3'd2, 32'h4000_0000, 0, 0, 0);
    in_data = 32'h7FC0_0000; trap_en = 1'b0; in_valid = 1'b1;
    #1;
    check("R10 stall ready", 64'(in_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R10 hold data", 64'(out_data), 64'h4000_0000);
    check("R10 hold class", 64'(out_class), 64'd2);
    out_ready = 1'b1;
    #1;
    check("R10 drain ready", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 R6 next data", 64'(out_data), 64'h7FBF_FFFF);
    check("R10 next valid", 64'(out_valid), 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_classes();
    t_quiet_nan();
    t_signal_nan();
    t_backpressure();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule